// File: doc/BRIEF.md
# Selectable Digital Modulation Generator

This block synthesizes a stream of 12-bit waveform samples that carry pseudo-random data on a sine carrier. A single pseudo-random bit source keys four modulators in parallel: on-off amplitude keying, two-tone frequency keying, two-phase keying and four-phase keying. A 2-bit mode input picks which of the four is presented at the output. All modulators run continuously, so switching modes never restarts a carrier or the data sequence.

Samples are produced at a fixed rate set by a clock divider. Each sample is marked by a one-cycle valid strobe. The data symbol changes after a fixed whole number of base carrier periods. The selected sample is a signed value, and it is sent out as unsigned offset binary by flipping its top bit. This lets it drive a unipolar digital-to-analog converter without further arithmetic.

Top module: `modgen_top`

## Requirements
- R1: While reset (`rstN` low) is applied and right after it, `sampleOut` is 0x800 (mid-scale) and `sampleValid` is 0. The random register restarts from its seed, 0xACE1 by default, and both carrier phases restart at 0.
- R2: `sampleValid` is a one-cycle pulse that repeats every `SAMPLE_DIV` clocks (default 2). `sampleOut` changes only in a cycle where `sampleValid` is high.
- R3: `sampleOut` is the selected signed 12-bit sample with bit 11 inverted and bits 10:0 unchanged (two's complement to offset binary).
- R4: The carrier value for a 6-bit phase p is round(2047·sin(2πp/64)). The base phase starts at 0 and advances by 1 after every sample.
- R5: The data source is a 16-bit register. Each step shifts it left and puts q[15]^q[13]^q[12]^q[10] into bit 0. It advances by two steps after every 512th sample (8 base carrier periods) and is never all-zero. Bit 0 is the data bit for the 1-bit schemes. Bits {1,0} form the symbol pair for four-phase keying.
- R6: Mode 00 (amplitude keying) outputs the carrier at the base phase when the data bit is 1, and 0 (0x800 at the port) when it is 0.
- R7: Mode 01 (frequency keying) outputs the sine of its own phase. That phase starts at 0 and advances by 1 per sample for data bit 0 and by 2 per sample for data bit 1.
- R8: Mode 10 (two-phase keying) outputs sin(base) for data bit 1 and sin(base+32), a 180° shift, for data bit 0.
- R9: Mode 11 (four-phase keying) adds a phase offset to the base phase according to the bit pair: 00 adds 0, 01 adds 16 (90°), 11 adds 32 (180°) and 10 adds 48 (270°).
- R10: A change of `modeSel` takes effect at the next sample. It does not disturb either phase or the data sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 2 | Scheme select: 00 amplitude, 01 frequency, 10 two-phase, 11 four-phase |
| sampleOut | output | 12 | Offset-binary output sample |
| sampleValid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The embedded properties check several rules on every cycle. The sample strobe must come out with the right spacing and the output must hold between strobes. The random register must never reach zero and may change only at symbol boundaries. Each phase must take the step it is owed, and amplitude keying with a zero bit must give mid-scale. The exact sine values, the Gray-coded phase offsets, the top-bit conversion and the behaviour of mode switches in the middle of a symbol can only be shown by the bench. It compares every sample against a model built on floating-point sine, while modes change at random points and a reset is applied mid-run.

// File: rtl/modgen_pkg.sv
package modgen_pkg;

  localparam int SAMPLE_W = 12;
  localparam int PHASE_W  = 6;

  typedef struct packed {
    logic sampleTick;
    logic symbolTick;
  } modStrobe_t;

  typedef enum logic [1:0] {
    MODE_ASK  = 2'b00,
    MODE_FSK  = 2'b01,
    MODE_BPSK = 2'b10,
    MODE_QPSK = 2'b11
  } modMode_t;

  // First quarter of a sine wave, 2047 peak, 16 steps per quarter
  function automatic logic signed [SAMPLE_W-1:0] quarterSine(input logic [4:0] k);
    case (k)
      5'd0:    return 12'sd0;
      5'd1:    return 12'sd201;
      5'd2:    return 12'sd399;
      5'd3:    return 12'sd594;
      5'd4:    return 12'sd783;
      5'd5:    return 12'sd965;
      5'd6:    return 12'sd1137;
      5'd7:    return 12'sd1299;
      5'd8:    return 12'sd1447;
      5'd9:    return 12'sd1582;
      5'd10:   return 12'sd1702;
      5'd11:   return 12'sd1805;
      5'd12:   return 12'sd1891;
      5'd13:   return 12'sd1959;
      5'd14:   return 12'sd2008;
      5'd15:   return 12'sd2037;
      default: return 12'sd2047;
    endcase
  endfunction

  // Full 64-step sine built from quarter symmetry
  function automatic logic signed [SAMPLE_W-1:0] sineAt(input logic [PHASE_W-1:0] p);
    logic [4:0] idx;
    logic [4:0] mirror;
    idx    = {1'b0, p[3:0]};
    mirror = 5'd16 - idx;
    case (p[5:4])
      2'd0:    return quarterSine(idx);
      2'd1:    return quarterSine(mirror);
      2'd2:    return -quarterSine(idx);
      default: return -quarterSine(mirror);
    endcase
  endfunction

  function automatic logic [15:0] lfsrStep(input logic [15:0] q);
    return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

endpackage

// File: rtl/modgen_ctrl.sv
module modgen_ctrl
  import modgen_pkg::*;
#(
  parameter int SAMPLE_DIV     = 2,
  parameter int SYMBOL_SAMPLES = 512
) (
  input  logic       clk,
  input  logic       rstN,
  output modStrobe_t strobe
);

  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int SYM_W = (SYMBOL_SAMPLES > 1) ? $clog2(SYMBOL_SAMPLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(SYMBOL_SAMPLES - 1);

  logic [DIV_W-1:0] divCnt;
  logic [SYM_W-1:0] symCnt;

  always_comb begin
    strobe.sampleTick = (divCnt == DIV_LAST);
    strobe.symbolTick = strobe.sampleTick && (symCnt == SYM_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      symCnt <= '0;
    end else begin
      divCnt <= strobe.sampleTick ? '0 : divCnt + 1'b1;
      if (strobe.sampleTick)
        symCnt <= strobe.symbolTick ? '0 : symCnt + 1'b1;
    end
  end

  generate
    if (SAMPLE_DIV > 1) begin : g_gapCheck
      p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
        strobe.sampleTick |=> !strobe.sampleTick);
    end
  endgenerate

endmodule

// File: rtl/modgen_datapath.sv
module modgen_datapath
  import modgen_pkg::*;
#(
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rstN,
  input  modStrobe_t          strobe,
  input  logic [1:0]          modeSel,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                sampleValid
);

  localparam logic [PHASE_W-1:0] HALF_TURN    = PHASE_W'(1 << (PHASE_W - 1));
  localparam logic [PHASE_W-1:0] QUARTER_TURN = PHASE_W'(1 << (PHASE_W - 2));

  logic [15:0]        lfsr;
  logic [PHASE_W-1:0] basePhase;
  logic [PHASE_W-1:0] fskPhase;
  logic               dataBit;
  logic [PHASE_W-1:0] qpskOffset;
  logic signed [SAMPLE_W-1:0] modSample [4];
  logic signed [SAMPLE_W-1:0] chosen;

  assign dataBit = lfsr[0];

  // Gray-coded four-phase offsets
  always_comb begin
    case (lfsr[1:0])
      2'b00:   qpskOffset = '0;
      2'b01:   qpskOffset = QUARTER_TURN;
      2'b11:   qpskOffset = HALF_TURN;
      default: qpskOffset = HALF_TURN + QUARTER_TURN;
    endcase
  end

  always_comb begin
    modSample[MODE_ASK]  = dataBit ? sineAt(basePhase) : '0;
    modSample[MODE_FSK]  = sineAt(fskPhase);
    modSample[MODE_BPSK] = sineAt(dataBit ? basePhase : basePhase + HALF_TURN);
    modSample[MODE_QPSK] = sineAt(basePhase + qpskOffset);
    chosen               = modSample[modeSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr        <= LFSR_SEED;
      basePhase   <= '0;
      fskPhase    <= '0;
      sampleOut   <= {1'b1, {(SAMPLE_W-1){1'b0}}};
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.sampleTick;
      if (strobe.sampleTick) begin
        basePhase <= basePhase + 1'b1;
        fskPhase  <= fskPhase + (dataBit ? PHASE_W'(2) : PHASE_W'(1));
        sampleOut <= {~chosen[SAMPLE_W-1], chosen[SAMPLE_W-2:0]};
      end
      if (strobe.symbolTick)
        lfsr <= lfsrStep(lfsrStep(lfsr));
    end
  end

  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  p_lfsr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.symbolTick |=> $stable(lfsr));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable(sampleOut));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleTick |=> sampleValid);

  p_base_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleTick |=> basePhase == $past(basePhase) + PHASE_W'(1));

  p_fsk_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleTick |=>
      fskPhase == $past(fskPhase) + ($past(lfsr[0]) ? PHASE_W'(2) : PHASE_W'(1)));

  p_ask_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleTick && modeSel == MODE_ASK && !lfsr[0] |=> sampleOut == 12'h800);

endmodule

// File: rtl/modgen_top.sv
module modgen_top
  import modgen_pkg::*;
#(
  parameter int          SAMPLE_DIV     = 2,
  parameter int          CARRIER_CYCLES = 8,
  parameter logic [15:0] LFSR_SEED      = 16'hACE1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  output logic [11:0] sampleOut,
  output logic        sampleValid
);

  localparam int SYMBOL_SAMPLES = CARRIER_CYCLES * (1 << PHASE_W);

  modStrobe_t strobe;

  modgen_ctrl #(
    .SAMPLE_DIV    (SAMPLE_DIV),
    .SYMBOL_SAMPLES(SYMBOL_SAMPLES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  modgen_datapath #(
    .LFSR_SEED(LFSR_SEED)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modeSel    (modeSel),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/modgen_top_bench.sv
`timescale 1ns/1ps
module modgen_top_bench;

  localparam int SAMPLE_DIV = 2;
  localparam int SYM_LEN    = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [11:0] sampleOut;
  logic        sampleValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [15:0] mLfsr;
  int          mBase, mFsk, mIdx;
  logic [11:0] lastOut;
  int          gap;
  bit          seenValid;

  always #2.5 clk = ~clk;

  modgen_top u_modgen_top (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sineRef(input int p);
    real s, r;
    s = $sin(2.0 * 3.14159265358979 * (p % 64) / 64.0);
    r = 2047.0 * s;
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic logic [15:0] stepRef(input logic [15:0] q);
    return {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  endfunction

  function automatic int qOffRef(input logic [1:0] pair);
    case (pair)
      2'b00: return 0;
      2'b01: return 16;
      2'b11: return 32;
      default: return 48;
    endcase
  endfunction

  function automatic logic [11:0] expectRef(input logic [1:0] m);
    int s;
    logic [11:0] v;
    case (m)
      2'b00: s = mLfsr[0] ? sineRef(mBase) : 0;             // R6
      2'b01: s = sineRef(mFsk);                              // R7
      2'b10: s = sineRef(mLfsr[0] ? mBase : mBase + 32);     // R8
      default: s = sineRef(mBase + qOffRef(mLfsr[1:0]));     // R9
    endcase
    v = s[11:0];
    v[11] = ~v[11];                                          // R3
    return v;
  endfunction

  task automatic modelReset();
    mLfsr = 16'hACE1; mBase = 0; mFsk = 0; mIdx = 0;
    lastOut = 12'h800; gap = 0; seenValid = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(sampleOut == 12'h800, "R1 reset sampleOut", sampleOut, 12'h800);
    check(sampleValid == 1'b0, "R1 reset sampleValid", sampleValid, 0);
    modelReset();
    rstN = 1'b1;
  endtask

  // one negedge step: check the port, then maybe change mode
  task automatic stepCycle(input bit randomMode, input logic [1:0] forced);
    @(negedge clk);
    gap++;
    if (sampleValid) begin
      if (seenValid)
        check(gap == SAMPLE_DIV, "R2 valid spacing", gap, SAMPLE_DIV);
      seenValid = 1'b1;
      gap = 0;
      check(sampleOut == expectRef(modeSel), "R3-R10 sample value mode",
            sampleOut, expectRef(modeSel));
      lastOut = sampleOut;
      // advance model (R4, R5, R7)
      mFsk  = (mFsk + (mLfsr[0] ? 2 : 1)) % 64;
      mBase = (mBase + 1) % 64;
      mIdx++;
      if (mIdx % SYM_LEN == 0) begin
        mLfsr = stepRef(stepRef(mLfsr));
        check(sampleOut != 12'hFFF || mLfsr != 0, "R5 lfsr nonzero", mLfsr, 1);
      end
    end else begin
      check(sampleOut == lastOut, "R2 hold between strobes", sampleOut, lastOut);
    end
    // R10: mode changes land between samples at arbitrary points
    if (randomMode) begin
      if ($urandom % 16 == 0) modeSel = 2'($urandom % 4);
    end else begin
      modeSel = forced;
    end
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'd4271);
    modelReset();
    applyReset();
    // directed: every mode for a whole symbol of samples each (R6..R9)
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < SYM_LEN * SAMPLE_DIV; c++)
        stepCycle(1'b0, 2'(m));
    // random mode switching over many symbols (R10)
    for (int c = 0; c < 50000; c++)
      stepCycle(1'b1, 2'b00);
    // mid-run reset, then restart from seed (R1)
    applyReset();
    for (int c = 0; c < 8000; c++)
      stepCycle(1'b1, 2'b00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule